// File: doc/BRIEF.md
# Flash Command Decoder with Status Register

This block is the command front end of a NOR-style flash device. The host drives single-cycle bus writes (`bus_we` with an address and a 16-bit data word), and the low byte of each write is a command code. The block selects what a read returns (array data, status, identifier or query). It runs the setup/confirm sequences for word program, block erase, protection setup and accelerated program. It hands each accepted operation to a write engine and keeps an 8-bit status register that the host polls.

The write engine is a timer stub inside the block. It stays busy for a fixed number of cycles for each kind of operation and can be told to report a failure (`eng_fault`). It can be paused and resumed. It holds one paused erase in reserve while a program started during an erase suspend runs to completion.

Decoder states: `ST_IDLE`, `ST_PSETUP` (program address/data awaited), `ST_ESETUP` (erase confirm awaited), `ST_PROT` (protection second cycle awaited), `ST_AADDR` (accelerated-program address awaited), `ST_ADATA` (accelerated-program words being collected), `ST_PRUN` (program running), `ST_ERUN` (erase running), `ST_PSUSP` (program suspended) and `ST_ESUSP` (erase suspended).

Transitions:
- IDLE→PSETUP on 40h, IDLE→ESETUP on 20h, IDLE→PROT on 60h, and IDLE→AADDR on 10h.
- PSETUP→PRUN on any write; ESETUP→ERUN on D0h; PROT→IDLE on any write.
- AADDR→ADATA on any write; ADATA→PRUN on the last word.
- PRUN→PSUSP and ERUN→ESUSP on B0h; PSUSP→PRUN and ESUSP→ERUN on D0h.
- ESUSP→PSETUP on 40h. This is a nested program: PRUN returns to ESUSP when it ends.
- PRUN→IDLE and ERUN→IDLE when the engine reports done.
- Every setup state returns to IDLE (or to ESUSP for a nested program) when the voltage or the sequence is bad.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, status reads 80h, the read mode is array (code 0) and the engine is not busy.
- R2: Read-mode codes are 0 array, 1 status, 2 identifier, 3 query. In idle or suspend states, FFh selects array, 70h status, 90h identifier and 98h query. Any other recognised command selects status. An unrecognised code (such as 55h) is ignored and selects array.
- R3: 40h followed by any write starts a program: `op_start` pulses during that write with `op_kind` 0 and that write's address. Status bit 7 reads 0 from the next cycle and returns to 1 exactly PROG_CYCLES+1 cycles after the starting write.
- R4: 20h followed by D0h starts an erase (`op_kind` 1). Any other second code starts nothing and sets status bits 5 and 4.
- R5: While an operation runs (status bit 7 = 0), every write except B0h leaves status and read mode unchanged. This includes 50h and FFh.
- R6: B0h during a program sets status bit 2; B0h during an erase sets status bit 6. In both cases bit 7 returns to 1 and the engine stops counting. D0h resumes the operation and clears the suspend bit. Read-mode commands act while suspended.
- R7: During an erase suspend, 40h and a data write start a program (`op_kind` 0) while bit 6 stays 1. When that program ends, the block is back in erase suspend (status C0h).
- R8: After 60h, a second code of 01h, 2Fh, 03h or D0h is accepted without error. Any other code sets status bits 5 and 4.
- R9: 10h, an address write and then ACC_WORDS data writes start an accelerated program on the last data write (`op_kind` 2, the captured address). 10h is refused while status bit 3 is set: no sequence opens and the next write is decoded as a first cycle.
- R10: If `vpp_ok` is low on the write that would start an operation, nothing starts. Status bit 3 is set, together with bit 4 for a program or accelerated program, or bit 5 for an erase.
- R11: An operation started with `eng_fault` high sets bit 4 (program) or bit 5 (erase) when it completes.
- R12: Status bits 5, 4 and 3 are sticky. Only 50h, accepted outside a run, clears them. Status layout: bit 7 ready, 6 erase suspended, 5 erase error, 4 program error, 3 voltage error, 2 program suspended, 1:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_data | input | 16 | Write data; the low byte is the command code |
| vpp_ok | input | 1 | Programming voltage is within range |
| eng_fault | input | 1 | Sampled at start; the engine then reports a failure |
| read_mode | output | 2 | Read source: 0 array, 1 status, 2 identifier, 3 query |
| status | output | 8 | Status register |
| op_start | output | 1 | Operation hand-off, high during the accepting write |
| op_kind | output | 2 | 0 program, 1 erase, 2 accelerated program |
| op_addr | output | ADDR_W | Address handed to the engine |
| eng_busy | output | 1 | Engine is counting (neither idle nor paused) |

## Verification
A wrong decoder state shows up on the status port in the cycle after the write that caused it. A missed suspend leaves bit 7 low. A lost nesting flag drops bit 6 while the nested program runs. A setup state left open swallows the next command, so `read_mode` fails to follow it one cycle later. Errors in the engine count or in the save/restore path show only at completion, so the reference model is compared on every cycle. It catches a ready bit that rises one cycle early or late, and an erase that resumes with the wrong remaining time.

// File: rtl/fce_pkg.sv
package fce_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PSETUP, ST_ESETUP, ST_PROT, ST_AADDR,
        ST_ADATA, ST_PRUN, ST_ERUN, ST_PSUSP, ST_ESUSP
    } dec_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_IDENT  = 2'd2,
        RM_QUERY  = 2'd3
    } rmode_e;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_ACCEL = 2'd2
    } op_kind_e;

    localparam logic [7:0] C_PROG    = 8'h40;
    localparam logic [7:0] C_ERASE   = 8'h20;
    localparam logic [7:0] C_CONFIRM = 8'hD0;
    localparam logic [7:0] C_SUSPEND = 8'hB0;
    localparam logic [7:0] C_RSTAT   = 8'h70;
    localparam logic [7:0] C_CLEAR   = 8'h50;
    localparam logic [7:0] C_RIDENT  = 8'h90;
    localparam logic [7:0] C_RQUERY  = 8'h98;
    localparam logic [7:0] C_RARRAY  = 8'hFF;
    localparam logic [7:0] C_PROT    = 8'h60;
    localparam logic [7:0] C_ACCEL   = 8'h10;
    localparam logic [7:0] C_LOCK    = 8'h01;
    localparam logic [7:0] C_LOCKDN  = 8'h2F;
    localparam logic [7:0] C_CFGWR   = 8'h03;

endpackage

// File: rtl/fce_engine_stub.sv
module fce_engine_stub
    import fce_pkg::*;
#(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 24,
    parameter int ACCEL_CYCLES = 12
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  op_kind_e kind,
    input  logic     fault,
    input  logic     suspend,
    input  logic     resume,
    output logic     busy,
    output logic     done,
    output logic     done_err
);
    localparam int MAXC_A = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int MAXC   = (MAXC_A > ACCEL_CYCLES) ? MAXC_A : ACCEL_CYCLES;
    localparam int CNT_W  = $clog2(MAXC + 1);

    logic             act_q, pause_q, err_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sv_q, sv_err_q;
    logic [CNT_W-1:0] sv_cnt_q;

    function automatic logic [CNT_W-1:0] op_len(op_kind_e k);
        unique case (k)
            OP_ERASE: return CNT_W'(ERASE_CYCLES);
            OP_ACCEL: return CNT_W'(ACCEL_CYCLES);
            default:  return CNT_W'(PROG_CYCLES);
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            pause_q  <= 1'b0;
            err_q    <= 1'b0;
            cnt_q    <= '0;
            sv_q     <= 1'b0;
            sv_err_q <= 1'b0;
            sv_cnt_q <= '0;
            done     <= 1'b0;
            done_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                if (act_q) begin
                    sv_q     <= 1'b1;
                    sv_cnt_q <= cnt_q;
                    sv_err_q <= err_q;
                end
                act_q   <= 1'b1;
                pause_q <= 1'b0;
                cnt_q   <= op_len(kind);
                err_q   <= fault;
            end else if (suspend) begin
                pause_q <= 1'b1;
            end else if (resume) begin
                pause_q <= 1'b0;
            end else if (act_q && !pause_q) begin
                if (cnt_q == CNT_W'(1)) begin
                    done     <= 1'b1;
                    done_err <= err_q;
                    if (sv_q) begin
                        cnt_q   <= sv_cnt_q;
                        err_q   <= sv_err_q;
                        pause_q <= 1'b1;
                        sv_q    <= 1'b0;
                    end else begin
                        act_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign busy = act_q && !pause_q;

endmodule

// File: rtl/fce_status_reg.sv
module fce_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_vpp,
    input  logic       set_perr,
    input  logic       set_eerr,
    input  logic       clr,
    input  logic       ready,
    input  logic       esusp,
    input  logic       psusp,
    output logic [7:0] status
);
    localparam int NSTICKY = 3;

    logic [NSTICKY-1:0] set_v;
    logic [NSTICKY-1:0] sticky_q;

    assign set_v = {set_eerr, set_perr, set_vpp};

    for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sticky_q[i] <= 1'b0;
            else if (set_v[i])
                sticky_q[i] <= 1'b1;
            else if (clr)
                sticky_q[i] <= 1'b0;
        end
    end

    assign status = {ready, esusp, sticky_q, psusp, 2'b00};

endmodule

// File: rtl/fce_cmd_fsm.sv
module fce_cmd_fsm
    import fce_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int ACC_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              vpp_ok,
    input  logic              vpp_err_flag,
    input  logic              eng_done,
    input  logic              eng_done_err,
    output logic              eng_start,
    output op_kind_e          eng_kind,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              eng_suspend,
    output logic              eng_resume,
    output logic              set_vpp,
    output logic              set_perr,
    output logic              set_eerr,
    output logic              clr_err,
    output rmode_e            mode,
    output logic              ready,
    output logic              esusp,
    output logic              psusp
);
    localparam int ACC_W = (ACC_WORDS > 1) ? $clog2(ACC_WORDS) : 1;

    dec_state_e        state_q, state_d;
    logic              nest_q, nest_d;
    logic [ACC_W-1:0]  acnt_q, acnt_d;
    logic [ADDR_W-1:0] aaddr_q, aaddr_d;
    rmode_e            mode_q, mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            nest_q  <= 1'b0;
            acnt_q  <= '0;
            aaddr_q <= '0;
            mode_q  <= RM_ARRAY;
        end else begin
            state_q <= state_d;
            nest_q  <= nest_d;
            acnt_q  <= acnt_d;
            aaddr_q <= aaddr_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        nest_d      = nest_q;
        acnt_d      = acnt_q;
        aaddr_d     = aaddr_q;
        mode_d      = mode_q;
        eng_start   = 1'b0;
        eng_kind    = OP_PROG;
        eng_addr    = addr;
        eng_suspend = 1'b0;
        eng_resume  = 1'b0;
        set_vpp     = 1'b0;
        set_perr    = 1'b0;
        set_eerr    = 1'b0;
        clr_err     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PSUSP, ST_ESUSP: begin
                if (we) begin
                    mode_d = RM_STATUS;
                    case (cmd)
                        C_RARRAY: mode_d = RM_ARRAY;
                        C_RSTAT:  mode_d = RM_STATUS;
                        C_RIDENT: mode_d = RM_IDENT;
                        C_RQUERY: mode_d = RM_QUERY;
                        C_CLEAR:  clr_err = 1'b1;
                        C_PROG: begin
                            if (state_q == ST_IDLE) begin
                                state_d = ST_PSETUP;
                            end else if (state_q == ST_ESUSP) begin
                                state_d = ST_PSETUP;
                                nest_d  = 1'b1;
                            end
                        end
                        C_ERASE: if (state_q == ST_IDLE) state_d = ST_ESETUP;
                        C_PROT:  if (state_q == ST_IDLE) state_d = ST_PROT;
                        C_ACCEL: if (state_q == ST_IDLE && !vpp_err_flag) state_d = ST_AADDR;
                        C_CONFIRM: begin
                            if (state_q == ST_PSUSP) begin
                                state_d    = ST_PRUN;
                                eng_resume = 1'b1;
                            end else if (state_q == ST_ESUSP) begin
                                state_d    = ST_ERUN;
                                eng_resume = 1'b1;
                            end
                        end
                        C_SUSPEND: mode_d = RM_STATUS;
                        default:   mode_d = RM_ARRAY;
                    endcase
                end
            end
            ST_PSETUP: begin
                if (we) begin
                    mode_d = RM_STATUS;
                    if (vpp_ok) begin
                        eng_start = 1'b1;
                        eng_kind  = OP_PROG;
                        state_d   = ST_PRUN;
                    end else begin
                        set_vpp  = 1'b1;
                        set_perr = 1'b1;
                        state_d  = nest_q ? ST_ESUSP : ST_IDLE;
                        nest_d   = 1'b0;
                    end
                end
            end
            ST_ESETUP: begin
                if (we) begin
                    mode_d  = RM_STATUS;
                    state_d = ST_IDLE;
                    if (cmd != C_CONFIRM) begin
                        set_perr = 1'b1;
                        set_eerr = 1'b1;
                    end else if (vpp_ok) begin
                        eng_start = 1'b1;
                        eng_kind  = OP_ERASE;
                        state_d   = ST_ERUN;
                    end else begin
                        set_vpp  = 1'b1;
                        set_eerr = 1'b1;
                    end
                end
            end
            ST_PROT: begin
                if (we) begin
                    mode_d  = RM_STATUS;
                    state_d = ST_IDLE;
                    if (cmd != C_LOCK && cmd != C_LOCKDN && cmd != C_CFGWR && cmd != C_CONFIRM) begin
                        set_perr = 1'b1;
                        set_eerr = 1'b1;
                    end
                end
            end
            ST_AADDR: begin
                if (we) begin
                    mode_d  = RM_STATUS;
                    aaddr_d = addr;
                    acnt_d  = '0;
                    state_d = ST_ADATA;
                end
            end
            ST_ADATA: begin
                if (we) begin
                    mode_d = RM_STATUS;
                    if (acnt_q == ACC_W'(ACC_WORDS - 1)) begin
                        if (vpp_ok) begin
                            eng_start = 1'b1;
                            eng_kind  = OP_ACCEL;
                            eng_addr  = aaddr_q;
                            state_d   = ST_PRUN;
                        end else begin
                            set_vpp  = 1'b1;
                            set_perr = 1'b1;
                            state_d  = ST_IDLE;
                        end
                    end else begin
                        acnt_d = acnt_q + ACC_W'(1);
                    end
                end
            end
            ST_PRUN: begin
                if (eng_done) begin
                    set_perr = eng_done_err;
                    state_d  = nest_q ? ST_ESUSP : ST_IDLE;
                    nest_d   = 1'b0;
                end else if (we && cmd == C_SUSPEND) begin
                    eng_suspend = 1'b1;
                    mode_d      = RM_STATUS;
                    state_d     = ST_PSUSP;
                end
            end
            ST_ERUN: begin
                if (eng_done) begin
                    set_eerr = eng_done_err;
                    state_d  = ST_IDLE;
                end else if (we && cmd == C_SUSPEND) begin
                    eng_suspend = 1'b1;
                    mode_d      = RM_STATUS;
                    state_d     = ST_ESUSP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign mode  = mode_q;
    assign ready = !(state_q == ST_PRUN || state_q == ST_ERUN);
    assign esusp = (state_q == ST_ESUSP) || nest_q;
    assign psusp = (state_q == ST_PSUSP);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fce_pkg::*;
#(
    parameter int ADDR_W       = 22,
    parameter int ACC_WORDS    = 32,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 24,
    parameter int ACCEL_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_data,
    input  logic              vpp_ok,
    input  logic              eng_fault,
    output logic [1:0]        read_mode,
    output logic [7:0]        status,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic              eng_busy
);
    op_kind_e kind_w;
    rmode_e   mode_w;
    logic     susp_w, res_w, done_w, derr_w;
    logic     s_vpp, s_perr, s_eerr, s_clr;
    logic     rdy_w, es_w, ps_w;

    fce_cmd_fsm #(.ADDR_W(ADDR_W), .ACC_WORDS(ACC_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .cmd(bus_data[7:0]), .addr(bus_addr),
        .vpp_ok(vpp_ok), .vpp_err_flag(status[3]), .eng_done(done_w), .eng_done_err(derr_w),
        .eng_start(op_start), .eng_kind(kind_w), .eng_addr(op_addr),
        .eng_suspend(susp_w), .eng_resume(res_w),
        .set_vpp(s_vpp), .set_perr(s_perr), .set_eerr(s_eerr), .clr_err(s_clr),
        .mode(mode_w), .ready(rdy_w), .esusp(es_w), .psusp(ps_w)
    );

    fce_engine_stub #(
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .ACCEL_CYCLES(ACCEL_CYCLES)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(op_start), .kind(kind_w), .fault(eng_fault),
        .suspend(susp_w), .resume(res_w), .busy(eng_busy), .done(done_w), .done_err(derr_w)
    );

    fce_status_reg u_sr (
        .clk(clk), .rst_n(rst_n), .set_vpp(s_vpp), .set_perr(s_perr), .set_eerr(s_eerr),
        .clr(s_clr), .ready(rdy_w), .esusp(es_w), .psusp(ps_w), .status(status)
    );

    assign op_kind   = kind_w;
    assign read_mode = mode_w;

endmodule

// File: rtl/fce_checker.sv
module fce_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [7:0] cmd,
    input logic [7:0] status,
    input logic [1:0] read_mode,
    input logic       op_start,
    input logic       eng_busy
);
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !status[7]);  // R3

    AST_START_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> status[7]);  // R5

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);  // R3

    AST_PSUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> status[7]);  // R6

    AST_MODE_FROZEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[7] && !(bus_we && cmd == 8'hB0)) |=> $stable(read_mode));  // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && cmd == 8'h50) |=> ((status[5:3] & $past(status[5:3])) == $past(status[5:3])));  // R12

endmodule

bind flash_cmd_ctrl fce_checker u_fce_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .cmd(bus_data[7:0]), .status(status),
    .read_mode(read_mode), .op_start(op_start), .eng_busy(eng_busy)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
    localparam int AW = 22, NW = 32, PC = 8, EC = 24, XC = 12;

    logic clk = 0, rst_n = 0, bus_we = 0, vpp_ok = 1, eng_fault = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic [1:0] read_mode, op_kind;
    logic [7:0] status;
    logic op_start, eng_busy;
    logic [AW-1:0] op_addr;

    int checks = 0, failures = 0, cyc = 0;
    bit done_flag = 0;
    logic st_seen;
    logic [1:0] kd_seen;
    logic [AW-1:0] ad_seen;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .ACC_WORDS(NW), .PROG_CYCLES(PC),
                     .ERASE_CYCLES(EC), .ACCEL_CYCLES(XC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_data(bus_data),
        .vpp_ok(vpp_ok), .eng_fault(eng_fault), .read_mode(read_mode), .status(status),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .eng_busy(eng_busy));

    // ---------------- behavioural reference model ----------------
    localparam int M_IDLE = 0, M_PSET = 1, M_ESET = 2, M_PROT = 3, M_AADR = 4,
                   M_ADAT = 5, M_PRUN = 6, M_ERUN = 7, M_PSUS = 8, M_ESUS = 9;
    int  ph, mode, acc_n, e_rem, s_rem;
    bit  nest, e_act, e_pause, e_err, s_val, s_err, d_p, d_e;
    bit  er_e, er_p, er_v;

    function automatic int op_cycles(int k);
        return (k == 1) ? EC : (k == 2) ? XC : PC;
    endfunction

    function automatic logic [7:0] model_status();
        return {(ph != M_PRUN && ph != M_ERUN), (ph == M_ESUS || nest), er_e, er_p, er_v,
                (ph == M_PSUS), 2'b00};
    endfunction

    always @(posedge clk) begin : model
        int c, k;
        bit st, su, re, se, sp, sv, clr, ndp;
        if (!rst_n) begin
            ph = M_IDLE; mode = 0; acc_n = 0; nest = 0;
            e_act = 0; e_pause = 0; e_rem = 0; e_err = 0; s_val = 0; s_rem = 0; s_err = 0;
            d_p = 0; d_e = 0; er_e = 0; er_p = 0; er_v = 0;
        end else begin
            c = int'(bus_data[7:0]); st = 0; su = 0; re = 0; se = 0; sp = 0; sv = 0; clr = 0; k = 0;
            if (ph == M_PRUN || ph == M_ERUN) begin
                if (d_p) begin
                    if (ph == M_PRUN) sp = d_e; else se = d_e;
                    ph = (ph == M_PRUN && nest) ? M_ESUS : M_IDLE; nest = 0;
                end else if (bus_we && c == 'hB0) begin
                    su = 1; mode = 1; ph = (ph == M_PRUN) ? M_PSUS : M_ESUS;
                end
            end else if (bus_we) begin
                mode = 1;
                if (ph == M_IDLE || ph == M_PSUS || ph == M_ESUS) begin
                    if (c == 'hFF) mode = 0;
                    else if (c == 'h90) mode = 2;
                    else if (c == 'h98) mode = 3;
                    else if (c == 'h50) clr = 1;
                    else if (c == 'h40) begin
                        if (ph == M_ESUS) nest = 1;
                        if (ph != M_PSUS) ph = M_PSET;
                    end
                    else if (c == 'h20) begin if (ph == M_IDLE) ph = M_ESET; end
                    else if (c == 'h60) begin if (ph == M_IDLE) ph = M_PROT; end
                    else if (c == 'h10) begin if (ph == M_IDLE && !er_v) ph = M_AADR; end
                    else if (c == 'hD0) begin
                        if (ph != M_IDLE) begin re = 1; ph = (ph == M_PSUS) ? M_PRUN : M_ERUN; end
                    end
                    else if (c != 'h70 && c != 'hB0) mode = 0;
                end else if (ph == M_PSET) begin
                    if (vpp_ok) begin st = 1; k = 0; ph = M_PRUN; end
                    else begin sv = 1; sp = 1; ph = nest ? M_ESUS : M_IDLE; nest = 0; end
                end else if (ph == M_ESET) begin
                    ph = M_IDLE;
                    if (c != 'hD0) begin sp = 1; se = 1; end
                    else if (vpp_ok) begin st = 1; k = 1; ph = M_ERUN; end
                    else begin sv = 1; se = 1; end
                end else if (ph == M_PROT) begin
                    ph = M_IDLE;
                    if (!(c == 'h01 || c == 'h2F || c == 'h03 || c == 'hD0)) begin sp = 1; se = 1; end
                end else if (ph == M_AADR) begin
                    acc_n = 0; ph = M_ADAT;
                end else if (ph == M_ADAT) begin
                    acc_n++;
                    if (acc_n == NW) begin
                        if (vpp_ok) begin st = 1; k = 2; ph = M_PRUN; end
                        else begin sv = 1; sp = 1; ph = M_IDLE; end
                    end
                end
            end
            if (clr) begin er_e = 0; er_p = 0; er_v = 0; end
            if (se) er_e = 1;
            if (sp) er_p = 1;
            if (sv) er_v = 1;
            ndp = 0;
            if (st) begin
                if (e_act) begin s_val = 1; s_rem = e_rem; s_err = e_err; end
                e_act = 1; e_pause = 0; e_rem = op_cycles(k); e_err = eng_fault;
            end else if (su) e_pause = 1;
            else if (re) e_pause = 0;
            else if (e_act && !e_pause) begin
                if (e_rem == 1) begin
                    ndp = 1; d_e = e_err;
                    if (s_val) begin e_rem = s_rem; e_err = s_err; e_pause = 1; s_val = 0; end
                    else e_act = 0;
                end else e_rem--;
            end
            d_p = ndp;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            checks++;
            if (status !== model_status() || read_mode !== 2'(mode) || eng_busy !== (e_act && !e_pause)) begin
                failures++;
                $display("FAIL model compare (R2 R3 R6 R12) cycle %0d: status=%h mode=%0d busy=%0d exp status=%h mode=%0d busy=%0d",
                         cyc, status, read_mode, eng_busy, model_status(), mode, e_act && !e_pause);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_data = d;
        #1;
        st_seen = op_start; kd_seen = op_kind; ad_seen = op_addr;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!status[7] && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int n;
        bit early;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", status, 'h80);
        chk("R1 reset mode", read_mode, 0);
        chk("R1 reset busy", eng_busy, 0);

        wr(0, 16'h00FF); chk("R2 FFh array", read_mode, 0);
        wr(0, 16'h0070); chk("R2 70h status", read_mode, 1);
        wr(0, 16'h0090); chk("R2 90h ident", read_mode, 2);
        wr(0, 16'h0098); chk("R2 98h query", read_mode, 3);
        wr(0, 16'h0055); chk("R2 unknown to array", read_mode, 0);
        chk("R2 unknown keeps status", status, 'h80);
        wr(0, 16'h0050); chk("R2 50h selects status", read_mode, 1);

        wr(0, 16'h0040);
        wr(22'h123, 16'hBEEF);
        chk("R3 start pulse", st_seen, 1);
        chk("R3 kind program", kd_seen, 0);
        chk("R3 address", ad_seen, 'h123);
        chk("R3 busy ready low", status[7], 0);
        wait_ready(n);
        chk("R3 busy duration", n, PC + 1);

        eng_fault = 1;
        wr(0, 16'h0040); wr(22'h8, 16'h1111);
        eng_fault = 0;
        wr(0, 16'h00FF);
        chk("R5 FFh ignored while running", read_mode, 1);
        chk("R5 still running", status[7], 0);
        wait_ready(n);
        chk("R11 program fault sets bit4", status, 'h90);
        wr(0, 16'h0040); wr(22'h9, 16'h2222);
        wr(0, 16'h0050);
        chk("R5 50h ignored while running", status[4], 1);
        wait_ready(n);
        chk("R12 error held after run", status, 'h90);
        wr(0, 16'h0050);
        chk("R12 50h clears errors", status, 'h80);

        wr(0, 16'h0020);
        wr(22'h2000, 16'h00D0);
        chk("R4 erase start", st_seen, 1);
        chk("R4 kind erase", kd_seen, 1);
        wr(0, 16'h00B0);
        chk("R6 erase suspended", status, 'hC0);
        chk("R6 engine paused", eng_busy, 0);
        wr(0, 16'h0040);
        wr(22'h10, 16'h1234);
        chk("R7 nested start", st_seen, 1);
        chk("R7 nested kind", kd_seen, 0);
        chk("R7 bit6 kept while nested runs", status, 'h40);
        wait_ready(n);
        chk("R7 back in erase suspend", status, 'hC0);
        chk("R7 erase still paused", eng_busy, 0);
        wr(0, 16'h00D0);
        chk("R6 erase resumed", status, 'h00);
        chk("R6 engine counting", eng_busy, 1);
        wait_ready(n);
        chk("R6 erase completes", status, 'h80);

        wr(0, 16'h0020); wr(22'h2000, 16'h0033);
        chk("R4 bad confirm no start", st_seen, 0);
        chk("R4 bad confirm bits", status, 'hB0);
        wr(0, 16'h0050);

        wr(0, 16'h0060); wr(0, 16'h0001); chk("R8 01h ok", status, 'h80);
        wr(0, 16'h0060); wr(0, 16'h002F); chk("R8 2Fh ok", status, 'h80);
        wr(0, 16'h0060); wr(0, 16'h0003); chk("R8 03h ok", status, 'h80);
        wr(0, 16'h0060); wr(0, 16'h0077); chk("R8 bad code error", status, 'hB0);
        wr(0, 16'h0050);

        vpp_ok = 0;
        wr(0, 16'h0040); wr(22'h5, 16'h0);
        chk("R10 program no start", st_seen, 0);
        chk("R10 program voltage bits", status, 'h98);
        wr(0, 16'h0020); wr(22'h5, 16'h00D0);
        chk("R10 erase no start", st_seen, 0);
        chk("R10 erase voltage bits", status, 'hB8);
        vpp_ok = 1;
        wr(0, 16'h0010);
        chk("R9 refused selects status", read_mode, 1);
        wr(0, 16'h00FF);
        chk("R9 refused, next is first cycle", read_mode, 0);
        chk("R9 refused, status kept", status, 'hB8);
        wr(0, 16'h0050);

        wr(0, 16'h0010);
        wr(22'h40, 16'h0);
        early = 0;
        for (int i = 0; i < NW - 1; i++) begin
            wr(22'h0, 16'(i));
            if (st_seen) early = 1;
        end
        chk("R9 no early start", early, 0);
        wr(22'h0, 16'hABCD);
        chk("R9 start on last word", st_seen, 1);
        chk("R9 kind accel", kd_seen, 2);
        chk("R9 captured address", ad_seen, 'h40);
        wait_ready(n);
        chk("R9 accel duration", n, XC + 1);

        wr(0, 16'h0040); wr(22'h7, 16'h7);
        wr(0, 16'h00B0);
        chk("R6 program suspended", status, 'h84);
        chk("R6 program paused", eng_busy, 0);
        wr(0, 16'h00FF);
        chk("R6 read mode during suspend", read_mode, 0);
        wr(0, 16'h00D0);
        chk("R6 program resumed", status, 'h00);
        wait_ready(n);
        chk("R6 program completes", status, 'h80);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule